// File: doc/BRIEF.md
# Windowed Watchdog Timer with Low-Power Hold

The block counts ticks of a slow internal oscillator and, if software fails to service it in time, raises a reset request. The count runs on the system clock and advances only on cycles where the slow-tick enable is high. A 3-bit period select sets the overflow length to a power of two slow ticks. A 2-bit window select sets how late in that period a restart is allowed. Software services the timer by writing a fixed key byte to the restart port. The write must land inside the open window. A write too early, or a write carrying any other byte, is treated as a fault, and so is letting the count run out. Each fault gives a one-cycle reset request.

A configuration input controls what happens in low-power states. When it is low, the oscillator may be stopped. In that case the count freezes, without being cleared, during halt or stop, and while the oscillator-stop control is set. When it is high, the count keeps running in all of these states. One combination of period and window select is illegal, and the block flags it on an error output.

Top module: `wdt_window_guard`

## Requirements
- R1: While `rst` is high, on the next clock `count` is 0 and `rst_req` and `cfg_err` are 0.
- R2: With P = 2^(MIN_EXP+per_sel), each running slow tick adds one to `count`. On the running tick where `count` is P-1 (or above), and no restart write is present, `count` goes to 0 and `rst_req` is high for that next cycle only.
- R3: A write (`wr_en` high) of 8'hAC while the window is open sets `count` to 0 and leaves `rst_req` low.
- R4: The window is open when `count` >= P*(3-win_sel)/4. Encodings 00, 01, 10 and 11 give the last quarter, last half, last three quarters and the whole period. An 8'hAC write while the window is closed clears `count` and pulses `rst_req`.
- R5: A write of any byte other than 8'hAC, with the window open or closed, clears `count` and pulses `rst_req` on the next cycle.
- R6: With `osc_keep` low, any of `halt_mode`, `stop_mode` or `osc_stop` high holds `count` at its value. Counting resumes from that value once all three are low.
- R7: With `osc_keep` high, `halt_mode`, `stop_mode` and `osc_stop` have no effect, and counting goes on.
- R8: `cfg_err` is high one cycle after `per_sel` is 000 and `win_sel` is 00, and low one cycle after any other pair.
- R9: A valid restart in the same cycle as the overflow tick wins. `count` goes to 0 and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable per slow oscillator period |
| per_sel | input | SEL_W | Overflow period select |
| win_sel | input | 2 | Window-open fraction select |
| osc_keep | input | 1 | 1: count runs in low-power states; 0: count may be frozen |
| halt_mode | input | 1 | CPU halt state active |
| stop_mode | input | 1 | CPU stop state active |
| osc_stop | input | 1 | Software request to stop the slow oscillator |
| wr_en | input | 1 | Restart register write strobe |
| wr_data | input | 8 | Byte written to the restart register |
| rst_req | output | 1 | One-cycle reset request |
| cfg_err | output | 1 | Illegal select combination flag |
| count | output | MIN_EXP+2^SEL_W | Present watchdog count |

## Verification
The most delicate cycle is the one where the last tick of the period and a restart write arrive together. The restart must cancel the overflow when the key is right. When the key is wrong, the two faults must merge into a single pulse. The bench sets this up on purpose: it runs the count to P-1 with the tick held high, then writes 8'hAC in that same cycle. Random writes that land on overflow ticks also hit this case. A reference model in the bench decides, from the requirements, whether a pulse is expected, and every cycle's `count` and `rst_req` are compared against it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] RESTART_KEY = 8'hAC;

  typedef enum logic [1:0] {
    WIN_LAST_QUARTER = 2'b00,
    WIN_LAST_HALF    = 2'b01,
    WIN_LAST_3Q      = 2'b10,
    WIN_ALWAYS       = 2'b11
  } win_sel_e;
endpackage

// File: rtl/wdt_limits.sv
module wdt_limits #(
  parameter int MIN_EXP = 10,
  parameter int SEL_W   = 3,
  localparam int NPER   = 1 << SEL_W,
  localparam int CNT_W  = MIN_EXP + NPER
) (
  input  logic [SEL_W-1:0] per_sel,
  input  logic [1:0]       win_sel,
  output logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] open_thr
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] per_tab [NPER];

  for (genvar i = 0; i < NPER; i++) begin : g_per
    localparam logic [CNT_W-1:0] PERIOD = CNT_W'(1) << (MIN_EXP + i);
    assign per_tab[i] = PERIOD;
  end

  logic [CNT_W-1:0] period;
  assign period   = per_tab[per_sel];
  assign last_cnt = period - CNT_W'(1);

  always_comb begin
    unique case (win_sel_e'(win_sel))
      WIN_LAST_QUARTER: open_thr = period - (period >> 2);
      WIN_LAST_HALF:    open_thr = period >> 1;
      WIN_LAST_3Q:      open_thr = period >> 2;
      default:          open_thr = '0;
    endcase
  end
endmodule

// File: rtl/wdt_run_gate.sv
module wdt_run_gate (
  input  logic slow_tick,
  input  logic osc_keep,
  input  logic halt_mode,
  input  logic stop_mode,
  input  logic osc_stop,
  output logic run
);
  logic frozen;
  assign frozen = !osc_keep && (halt_mode || stop_mode || osc_stop);
  assign run    = slow_tick && !frozen;
endmodule

// File: rtl/wdt_window_guard.sv
module wdt_window_guard #(
  parameter int MIN_EXP = 10,
  parameter int SEL_W   = 3,
  localparam int CNT_W  = MIN_EXP + (1 << SEL_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_tick,
  input  logic [SEL_W-1:0] per_sel,
  input  logic [1:0]       win_sel,
  input  logic             osc_keep,
  input  logic             halt_mode,
  input  logic             stop_mode,
  input  logic             osc_stop,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             rst_req,
  output logic             cfg_err,
  output logic [CNT_W-1:0] count
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] open_thr;
  logic             run;

  wdt_limits #(.MIN_EXP(MIN_EXP), .SEL_W(SEL_W)) u_limits (
    .per_sel (per_sel),
    .win_sel (win_sel),
    .last_cnt(last_cnt),
    .open_thr(open_thr)
  );

  wdt_run_gate u_gate (
    .slow_tick(slow_tick),
    .osc_keep (osc_keep),
    .halt_mode(halt_mode),
    .stop_mode(stop_mode),
    .osc_stop (osc_stop),
    .run      (run)
  );

  logic win_open, good_wr, bad_wr, ovf_hit;
  assign win_open = count >= open_thr;
  assign good_wr  = wr_en && (wr_data == RESTART_KEY) && win_open;
  assign bad_wr   = wr_en && !good_wr;
  assign ovf_hit  = run && (count >= last_cnt) && !good_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      rst_req <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (wr_en || ovf_hit)
        count <= '0;
      else if (run)
        count <= count + CNT_W'(1);
      rst_req <= bad_wr || ovf_hit;
      cfg_err <= (per_sel == '0) && (win_sel == 2'b00);
    end
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int MIN_EXP = 10,
  parameter int SEL_W   = 3,
  localparam int CNT_W  = MIN_EXP + (1 << SEL_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             slow_tick,
  input logic [SEL_W-1:0] per_sel,
  input logic [1:0]       win_sel,
  input logic             osc_keep,
  input logic             halt_mode,
  input logic             stop_mode,
  input logic             osc_stop,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             rst_req,
  input logic             cfg_err,
  input logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] c_per, c_thr;
  logic c_run, c_key, was_rst;

  always_comb begin
    c_per = CNT_W'(1) << (MIN_EXP + int'(per_sel));
    case (win_sel)
      2'b00:   c_thr = (c_per >> 1) + (c_per >> 2);
      2'b01:   c_thr = c_per >> 1;
      2'b10:   c_thr = c_per >> 2;
      default: c_thr = '0;
    endcase
  end
  assign c_run = slow_tick && (osc_keep || !(halt_mode || stop_mode || osc_stop));
  assign c_key = wr_data == 8'hAC;

  always_ff @(posedge clk) was_rst <= rst;

  always @(posedge clk)
    if (was_rst) a_r1_reset_state: assert (count == '0 && !rst_req && !cfg_err);

  a_r2_overflow: assert property (@(posedge clk) disable iff (rst)
    c_run && !wr_en && count >= c_per - CNT_W'(1) |=> count == '0 && rst_req);
  a_r3_restart_ok: assert property (@(posedge clk) disable iff (rst)
    wr_en && c_key && count >= c_thr |=> count == '0 && !rst_req);
  a_r4_early_write: assert property (@(posedge clk) disable iff (rst)
    wr_en && c_key && count < c_thr |=> count == '0 && rst_req);
  a_r5_bad_key: assert property (@(posedge clk) disable iff (rst)
    wr_en && !c_key |=> count == '0 && rst_req);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !osc_keep && (halt_mode || stop_mode || osc_stop) && !wr_en |=> $stable(count) && !rst_req);
  a_r7_keep_running: assert property (@(posedge clk) disable iff (rst)
    osc_keep && slow_tick && !wr_en && count < c_per - CNT_W'(1) |=> count == $past(count) + CNT_W'(1));
  a_r8_cfg_err: assert property (@(posedge clk) disable iff (rst)
    per_sel == '0 && win_sel == 2'b00 |=> cfg_err);
  a_r9_restart_wins: assert property (@(posedge clk) disable iff (rst)
    c_run && count >= c_per - CNT_W'(1) && wr_en && c_key && count >= c_thr |=> !rst_req);
endmodule

bind wdt_window_guard wdt_guard_chk #(.MIN_EXP(MIN_EXP), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .slow_tick(slow_tick), .per_sel(per_sel), .win_sel(win_sel),
  .osc_keep(osc_keep), .halt_mode(halt_mode), .stop_mode(stop_mode), .osc_stop(osc_stop),
  .wr_en(wr_en), .wr_data(wr_data), .rst_req(rst_req), .cfg_err(cfg_err), .count(count)
);

// File: tb/wdt_window_guard_bench.sv
`timescale 1ns/1ps
module wdt_window_guard_bench;
  localparam int MIN_EXP = 4;
  localparam int SEL_W   = 3;
  localparam int CNT_W   = MIN_EXP + (1 << SEL_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_tick = 1'b0;
  logic [SEL_W-1:0] per_sel = '0;
  logic [1:0] win_sel = 2'b01;
  logic osc_keep = 1'b1, halt_mode = 1'b0, stop_mode = 1'b0, osc_stop = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rst_req, cfg_err;
  logic [CNT_W-1:0] count;

  int total = 0, bad = 0;
  int m_cnt = 0;
  bit m_req = 0, m_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_window_guard #(.MIN_EXP(MIN_EXP), .SEL_W(SEL_W)) u_wdt_window_guard (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .per_sel(per_sel), .win_sel(win_sel),
    .osc_keep(osc_keep), .halt_mode(halt_mode), .stop_mode(stop_mode), .osc_stop(osc_stop),
    .wr_en(wr_en), .wr_data(wr_data), .rst_req(rst_req), .cfg_err(cfg_err), .count(count)
  );

  function automatic int period_of(input int sel);
    return 1 << (MIN_EXP + sel);
  endfunction

  function automatic int thr_of(input int sel, input int win);
    return period_of(sel) * (3 - win) / 4;
  endfunction

  task automatic step(input string tag);
    int p;
    bit run, good, ovf;
    if (rst) begin
      m_cnt = 0; m_req = 0; m_err = 0;
    end else begin
      p    = period_of(int'(per_sel));
      run  = slow_tick && (osc_keep || !(halt_mode || stop_mode || osc_stop));
      good = wr_en && wr_data == 8'hAC && m_cnt >= thr_of(int'(per_sel), int'(win_sel));
      ovf  = run && m_cnt >= p - 1 && !good;
      m_req = (wr_en && !good) || ovf;
      if (wr_en || ovf) m_cnt = 0;
      else if (run) m_cnt = m_cnt + 1;
      m_err = (per_sel == 0) && (win_sel == 2'b00);
    end
    @(posedge clk);
    #1;
    total++;
    if (int'(count) != m_cnt || rst_req !== m_req || cfg_err !== m_err) begin
      bad++;
      $display("FAIL %s: count=%0d rst_req=%0b cfg_err=%0b expected count=%0d rst_req=%0b cfg_err=%0b",
               tag, count, rst_req, cfg_err, m_cnt, m_req, m_err);
    end
  endtask

  task automatic run_to(input int target, input string tag);
    for (int k = 0; k < 5000 && m_cnt != target; k++) step(tag);
  endtask

  task automatic write_once(input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_data = d;
    step(tag);
    wr_en = 1'b0;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    #1;
    repeat (3) step("R1");
    rst = 1'b0;

    // R2: period 16 with window half, two wraps
    slow_tick = 1'b1; per_sel = 0; win_sel = 2'b01; osc_keep = 1'b1;
    for (int i = 0; i < 40; i++) step("R2");
    // R8: illegal combination flagged, then cleared
    win_sel = 2'b00; step("R8"); step("R8");
    win_sel = 2'b01; step("R8");
    // R4: early key write
    run_to(2, "R2"); write_once(8'hAC, "R4");
    // R3: key inside window
    run_to(12, "R2"); write_once(8'hAC, "R3");
    // R5: wrong key while open and while closed
    run_to(9, "R2"); write_once(8'h55, "R5");
    write_once(8'hAD, "R5");
    // R9: valid key on overflow tick
    run_to(15, "R2"); write_once(8'hAC, "R9");
    step("R9");
    // R6: frozen count in each low-power cause
    osc_keep = 1'b0; run_to(5, "R2");
    halt_mode = 1'b1; for (int i = 0; i < 6; i++) step("R6");
    halt_mode = 1'b0; stop_mode = 1'b1; for (int i = 0; i < 6; i++) step("R6");
    stop_mode = 1'b0; osc_stop = 1'b1; for (int i = 0; i < 6; i++) step("R6");
    osc_stop = 1'b0; for (int i = 0; i < 3; i++) step("R6");
    // R7: kept running through the same causes, incl. overflow
    osc_keep = 1'b1; halt_mode = 1'b1; stop_mode = 1'b1; osc_stop = 1'b1;
    for (int i = 0; i < 20; i++) step("R7");
    halt_mode = 1'b0; stop_mode = 1'b0; osc_stop = 1'b0;
    // R4 window fractions: quarter window on period 32
    per_sel = 1; win_sel = 2'b00;
    write_once(8'hAC, "R4"); run_to(23, "R4"); write_once(8'hAC, "R4");
    run_to(24, "R3"); write_once(8'hAC, "R3");
    win_sel = 2'b11; write_once(8'hAC, "R4");

    // Random segments
    for (int s = 0; s < 40; s++) begin
      per_sel  = SEL_W'($urandom_range(0, 3));
      win_sel  = 2'($urandom_range(0, 3));
      osc_keep = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 4) == 0) begin rst = 1'b1; step("R1"); rst = 1'b0; end
      for (int i = 0; i < 120; i++) begin
        slow_tick = ($urandom_range(0, 3) != 0);
        halt_mode = ($urandom_range(0, 9) == 0);
        stop_mode = ($urandom_range(0, 14) == 0);
        osc_stop  = ($urandom_range(0, 19) == 0);
        wr_en     = ($urandom_range(0, 29) == 0);
        wr_data   = ($urandom_range(0, 4) == 0) ? 8'($urandom_range(0, 255)) : 8'hAC;
        step("R2/R3/R5/R6/R9");
      end
      wr_en = 1'b0;
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: bench hung, actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule